// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver

This block receives 8-bit frames from a clocked synchronous serial link. An external serial clock and a serial data line are brought into the system-clock domain through two-flop synchronizers. On each rising edge of the serial clock one data bit is taken into a hidden shift register, least-significant bit first. After the eighth bit the byte moves into a host-visible data register and a receive-full flag is raised.

If a frame completes while the previous byte is still unread, the block records an overrun. The old byte is kept and the full flag stays set. The receiver then stalls and accepts no frame until software has cleared both the overrun flag and the full flag. Two level interrupt requests follow the flags: one for received data and one for receive errors. A single receive-interrupt enable gates both of them.

A small controller with three states sequences reception. RX_OFF is the state while reception is disabled. RX_SHIFT collects bits. RX_STALL is entered on an overrun. The transitions are named as follows:
- T_START: RX_OFF to RX_SHIFT, taken when the enable is high and no overrun is pending.
- T_STOP: RX_SHIFT to RX_OFF, taken when the enable drops.
- T_OVERRUN: RX_SHIFT to RX_STALL, taken when a frame completes while the full flag is set.
- T_RESUME: RX_STALL to RX_SHIFT, taken when both flags are clear and the enable is high.
- T_PARK: RX_STALL to RX_OFF, taken when both flags are clear and the enable is low.

Top module: `sync_serial_rx`

## Requirements
- R1: After reset, rx_data is 0x00 and rx_full, rx_ovr, irq_data and irq_err are all 0.
- R2: Bits are sampled on rising edges of sclk. The first bit of a frame lands in rx_data bit 0 and the eighth bit lands in bit 7.
- R3: When a frame completes while rx_full is 0, rx_data takes the byte and rx_full becomes 1, within 4 system clocks of the eighth sclk rising edge.
- R4: A frame of fewer than 8 bits changes neither rx_data nor rx_full.
- R5: When a frame completes while rx_full is 1, rx_ovr becomes 1, rx_data keeps the old byte and rx_full stays 1.
- R6: irq_data is high exactly while rx_full is 1 and rie is 1.
- R7: irq_err is high exactly while rx_ovr is 1 and rie is 1.
- R8: After an overrun, every frame is ignored until rx_ovr and rx_full have both been cleared. The first complete frame after that is received normally.
- R9: A status write (st_we high) clears rx_full when st_wdata bit 0 is 0 and clears rx_ovr when st_wdata bit 1 is 0. A bit written as 1 leaves its flag unchanged.
- R10: Dropping rx_en discards any partial frame. After rx_en rises again, the next sclk rising edge is bit 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdata | input | 1 | Serial data, least-significant bit first |
| rx_en | input | 1 | Receive enable |
| rie | input | 1 | Shared enable for both interrupt requests |
| st_we | input | 1 | Status write strobe |
| st_wdata | input | 2 | Status write value: bit 0 is full, bit 1 is overrun; 0 clears |
| rx_data | output | 8 | Last accepted byte |
| rx_full | output | 1 | Receive-full flag |
| rx_ovr | output | 1 | Overrun flag |
| irq_data | output | 1 | Received-data interrupt request (level) |
| irq_err | output | 1 | Receive-error interrupt request (level) |

## Verification
The assertions assume two things about the inputs. First, sclk and sdata change slowly compared with the system clock. Second, sdata is steady around each sclk rising edge, so the two synchronized lines stay aligned and each serial clock edge produces exactly one detected rise. The stimulus holds each sclk phase for four system clocks and changes sdata only at the start of the low phase. Status writes last exactly one cycle and are placed away from frame completion.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;
    typedef enum logic [1:0] {
        RX_OFF   = 2'd0,
        RX_SHIFT = 2'd1,
        RX_STALL = 2'd2
    } rx_state_t;

    localparam int unsigned ST_FULL_BIT = 0;
    localparam int unsigned ST_OVR_BIT  = 1;
    localparam int unsigned ST_W        = 2;
endpackage

// File: rtl/ssrx_sync.sv
module ssrx_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= d_in;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/ssrx_shifter.sv
module ssrx_shifter #(
    parameter int unsigned FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               step,
    input  logic               bit_in,
    output logic               done,
    output logic [FRAME_W-1:0] frame
);
    localparam int unsigned CNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (clear) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (step) begin
            shreg <= {bit_in, shreg[FRAME_W-1:1]};
            cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign done  = step && !clear && (cnt == LAST);
    assign frame = {bit_in, shreg[FRAME_W-1:1]};
endmodule

// File: rtl/ssrx_ctrl.sv
module ssrx_ctrl
    import ssrx_pkg::*;
#(
    parameter int unsigned FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_en,
    input  logic               frame_done,
    input  logic [FRAME_W-1:0] frame,
    input  logic               st_we,
    input  logic [ST_W-1:0]    st_wdata,
    output logic               shift_on,
    output logic [FRAME_W-1:0] data_q,
    output logic               full_q,
    output logic               ovr_q
);
    rx_state_t st, st_nx;
    logic accept, load, ovr_set, clr_full, clr_ovr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= RX_OFF;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            RX_OFF: begin
                if (rx_en && !ovr_q) st_nx = RX_SHIFT;               // T_START
            end
            RX_SHIFT: begin
                if (frame_done && full_q) st_nx = RX_STALL;          // T_OVERRUN
                else if (!rx_en)          st_nx = RX_OFF;            // T_STOP
            end
            RX_STALL: begin
                if (!full_q && !ovr_q) st_nx = rx_en ? RX_SHIFT      // T_RESUME
                                                     : RX_OFF;       // T_PARK
            end
            default: st_nx = RX_OFF;
        endcase
    end

    always_comb begin
        shift_on = (st == RX_SHIFT) && rx_en;
        accept   = (st == RX_SHIFT) && frame_done;
        load     = accept && !full_q;
        ovr_set  = accept && full_q;
        clr_full = st_we && !st_wdata[ST_FULL_BIT];
        clr_ovr  = st_we && !st_wdata[ST_OVR_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (load) data_q <= frame;
            if (load)          full_q <= 1'b1;
            else if (clr_full) full_q <= 1'b0;
            if (ovr_set)       ovr_q  <= 1'b1;
            else if (clr_ovr)  ovr_q  <= 1'b0;
        end
    end
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
    import ssrx_pkg::*;
#(
    parameter int unsigned FRAME_W     = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               sdata,
    input  logic               rx_en,
    input  logic               rie,
    input  logic               st_we,
    input  logic [1:0]         st_wdata,
    output logic [FRAME_W-1:0] rx_data,
    output logic               rx_full,
    output logic               rx_ovr,
    output logic               irq_data,
    output logic               irq_err
);
    logic [1:0]         pins_s;
    logic               sclk_d;
    logic               rise;
    logic               shift_on;
    logic               frame_done;
    logic [FRAME_W-1:0] frame;

    ssrx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({sclk, sdata}),
        .d_out (pins_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= pins_s[1];
    end

    assign rise = pins_s[1] && !sclk_d;

    ssrx_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!shift_on),
        .step   (rise),
        .bit_in (pins_s[0]),
        .done   (frame_done),
        .frame  (frame)
    );

    ssrx_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .frame_done (frame_done),
        .frame      (frame),
        .st_we      (st_we),
        .st_wdata   (st_wdata[ST_W-1:0]),
        .shift_on   (shift_on),
        .data_q     (rx_data),
        .full_q     (rx_full),
        .ovr_q      (rx_ovr)
    );

    assign irq_data = rx_full && rie;
    assign irq_err  = rx_ovr && rie;
endmodule

// File: rtl/ssrx_checker.sv
module ssrx_checker #(
    parameter int unsigned FRAME_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rie,
    input logic               st_we,
    input logic [1:0]         st_wdata,
    input logic [FRAME_W-1:0] rx_data,
    input logic               rx_full,
    input logic               rx_ovr,
    input logic               irq_data,
    input logic               irq_err
);
    AST_DATA_ONLY_ON_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> $rose(rx_full)); // R3

    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr |=> $stable(rx_data)); // R5

    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovr) |-> $past(rx_full)); // R5

    AST_DATA_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_data) |-> ($rose(rx_full) || $rose(rie))); // R6

    AST_ERR_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_err) |-> (!rx_ovr || !rie)); // R7

    AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && st_wdata[0] && rx_full) |=> rx_full); // R9
endmodule

bind sync_serial_rx ssrx_checker #(.FRAME_W(FRAME_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rie      (rie),
    .st_we    (st_we),
    .st_wdata (st_wdata),
    .rx_data  (rx_data),
    .rx_full  (rx_full),
    .rx_ovr   (rx_ovr),
    .irq_data (irq_data),
    .irq_err  (irq_err)
);

// File: tb/sync_serial_rx_bench.sv
module sync_serial_rx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCLK  = 4;
    localparam int NVEC       = 6;
    // bit 8 = rie, bits 7:0 = byte sent
    localparam logic [8:0] VEC [NVEC] = '{
        9'h1A5, 9'h03C, 9'h180, 9'h001, 9'h1FF, 9'h06E
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0, sdata = 1'b0, rx_en = 1'b0, rie = 1'b0, st_we = 1'b0;
    logic [1:0] st_wdata = 2'b11;
    logic [7:0] rx_data;
    logic       rx_full, rx_ovr, irq_data, irq_err;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_serial_rx u_sync_serial_rx (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .rx_en(rx_en),
        .rie(rie), .st_we(st_we), .st_wdata(st_wdata), .rx_data(rx_data),
        .rx_full(rx_full), .rx_ovr(rx_ovr), .irq_data(irq_data), .irq_err(irq_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sdata = b[i];
            sclk  = 1'b0;
            repeat (HALF_SCLK) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF_SCLK) @(negedge clk);
        end
        sclk = 1'b0;
        repeat (HALF_SCLK) @(negedge clk);
    endtask

    task automatic st_write(input logic [1:0] v);
        @(negedge clk);
        st_we = 1'b1;
        st_wdata = v;
        @(negedge clk);
        st_we = 1'b0;
        st_wdata = 2'b11;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 data", rx_data, 8'h00);
        check("R1 full", rx_full, 0);
        check("R1 ovr", rx_ovr, 0);
        check("R1 irqs", {irq_data, irq_err}, 2'b00);
        rst_n = 1'b1;
        rx_en = 1'b1;
        repeat (3) @(negedge clk);

        // Table walk: each byte received normally, then read by clearing full
        for (int v = 0; v < NVEC; v++) begin
            rie = VEC[v][8];
            send_bits(VEC[v][7:0], 8);
            check("R2 R3 data", rx_data, VEC[v][7:0]);
            check("R3 full", rx_full, 1);
            check("R6 irq_data", irq_data, VEC[v][8]);
            check("R5 no ovr", rx_ovr, 0);
            st_write(2'b10);
            check("R9 full cleared", rx_full, 0);
            check("R6 irq_data low", irq_data, 0);
        end

        // R4 partial frame, then R10 enable drop discards it
        rie = 1'b1;
        send_bits(8'hFF, 5);
        check("R4 full", rx_full, 0);
        check("R4 data", rx_data, VEC[NVEC-1][7:0]);
        @(negedge clk) rx_en = 1'b0;
        repeat (3) @(negedge clk);
        rx_en = 1'b1;
        repeat (3) @(negedge clk);
        send_bits(8'h5A, 8);
        check("R10 data", rx_data, 8'h5A);
        check("R10 full", rx_full, 1);

        // R5 overrun
        send_bits(8'hC3, 8);
        check("R5 ovr", rx_ovr, 1);
        check("R5 data kept", rx_data, 8'h5A);
        check("R5 full kept", rx_full, 1);
        check("R7 irq_err", irq_err, 1);
        rie = 1'b0;
        @(negedge clk);
        check("R7 irq_err gated", irq_err, 0);
        check("R6 irq_data gated", irq_data, 0);
        rie = 1'b1;

        // R8 stalled: frames ignored
        send_bits(8'h11, 8);
        check("R8 data while ovr", rx_data, 8'h5A);
        st_write(2'b11);
        check("R9 write ones keeps full", rx_full, 1);
        check("R9 write ones keeps ovr", rx_ovr, 1);
        st_write(2'b01);
        check("R9 ovr cleared", rx_ovr, 0);
        check("R7 irq_err dropped", irq_err, 0);
        check("R9 full kept", rx_full, 1);
        send_bits(8'h22, 8);
        check("R8 data while full only", rx_data, 8'h5A);
        check("R8 no new ovr", rx_ovr, 0);
        st_write(2'b00);
        check("R8 full cleared", rx_full, 0);
        repeat (3) @(negedge clk);
        send_bits(8'h96, 8);
        check("R8 resumed data", rx_data, 8'h96);
        check("R8 resumed full", rx_full, 1);
        check("R8 resumed ovr", rx_ovr, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule